// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a downstream FPGA over its slave-serial pins. A single-cycle start pulse begins a run. The block first drives the active-low program pin high for one cycle. It then pulls that pin low and waits for the target's init pin to fall. After that it releases the program pin and waits for init to rise again.

It then takes bitstream bytes from a valid/ready stream and shifts them out on a data/clock pin pair. The byte flagged as last closes the stream. The block then waits for the target's done pin. Once done is seen, it applies a two-phase reset pattern to the freshly configured logic and finishes with an ok status.

Each of the three waits has its own timeout, measured in pulses of a microsecond tick input, and its own error code. After a run ends, with success or with an error, the block holds its result and accepts nothing until the next start pulse. Init and done pass through a synchronizer before use.

Top module: `fpga_cfg_seq`

## Requirements
- R1: While reset is asserted, and whenever the block is not busy, `prog_n_o` is 1 (released), `in_ready_o` is 0, and `cclk_o` and `din_o` are 0.
- R2: A start pulse accepted while idle drives `prog_n_o` high in the following cycle and low in the cycle after that.
- R3: If init stays high for `INIT_LO_US` ticks while program is asserted, the run ends with `status_o` = 1.
- R4: If init stays low for `INIT_HI_US` ticks after program is released, the run ends with `status_o` = 2.
- R5: Each accepted byte is shifted most significant bit first, one bit per `cclk_o` period. `din_o` is set while `cclk_o` is low and is unchanged on the cycle `cclk_o` rises, where the target samples it.
- R6: If done stays low for `DONE_US` ticks after the last bit, the run ends with `status_o` = 3.
- R7: After done is seen, the block holds `prog_n_o`=1, `cclk_o`=1 and `din_o`=0 for `RST_US` ticks, then holds `din_o`=1 with the other two pins unchanged for another `RST_US` ticks. The run then ends with `status_o` = 0.
- R8: Once a run has ended, `fin_o` and `status_o` hold and `in_ready_o` stays 0 until the next start pulse, which begins a fresh run.
- R9: `busy_o` is 1 from the cycle after an accepted start until the run ends, and it is never high together with `fin_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per microsecond |
| start_i | input | 1 | Begin a configuration run |
| in_data_i | input | DW | Bitstream byte |
| in_valid_i | input | 1 | Byte valid |
| in_last_i | input | 1 | Byte is the final one of the bitstream |
| in_ready_o | output | 1 | Byte accepted when high together with valid |
| init_i | input | 1 | Target init pin level |
| done_i | input | 1 | Target done pin level |
| prog_n_o | output | 1 | Target program pin, active low |
| cclk_o | output | 1 | Configuration clock to target |
| din_o | output | 1 | Configuration data to target |
| busy_o | output | 1 | A run is in progress |
| fin_o | output | 1 | Last run has ended; result valid |
| status_o | output | 2 | 0 ok, 1 init-low timeout, 2 init-high timeout, 3 done timeout |

## Verification
The bench builds the block with timeouts of 6, 6 and 8 ticks and a reset phase of 3 ticks, and generates a tick every 4 clock cycles. With these values every timeout error and both reset-pattern phases complete within a few dozen cycles, so each error code and the exact phase lengths can be reached many times in one run. A model of the target answers program with random init and done delays and captures data on rising configuration clock edges, so byte order and the handshake are checked against randomly sized, gapped streams.

// File: rtl/fpga_cfg_pkg.sv
package fpga_cfg_pkg;
  typedef enum logic [3:0] {
    CS_IDLE, CS_PROG_HI, CS_PROG_LO, CS_WAIT_INIT, CS_SHIFT,
    CS_WAIT_DONE, CS_RST_LO, CS_RST_HI, CS_END
  } cfg_state_e;

  localparam logic [1:0] RES_OK      = 2'd0;
  localparam logic [1:0] RES_INIT_LO = 2'd1;
  localparam logic [1:0] RES_INIT_HI = 2'd2;
  localparam logic [1:0] RES_DONE    = 2'd3;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_ff
    logic [W-1:0] pipe [STAGES];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      end else begin
        pipe[0] <= d_i;
        for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
    end
    assign q_o = pipe[STAGES-1];
  end
endmodule

// File: rtl/cfg_tick_timer.sv
module cfg_tick_timer #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (tick_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  input  logic          last_i,
  output logic          ready_o,
  output logic          cclk_o,
  output logic          din_o,
  output logic          last_bit_o
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sr_q;
  logic [BW-1:0] idx_q;
  logic          ph_q, full_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      idx_q  <= '0;
      ph_q   <= 1'b0;
      full_q <= 1'b0;
      last_q <= 1'b0;
    end else if (!en_i) begin
      full_q <= 1'b0;
      ph_q   <= 1'b0;
    end else if (!full_q) begin
      if (valid_i) begin
        sr_q   <= data_i;
        last_q <= last_i;
        full_q <= 1'b1;
        ph_q   <= 1'b0;
        idx_q  <= '0;
      end
    end else if (!ph_q) begin
      ph_q <= 1'b1;
    end else begin
      ph_q  <= 1'b0;
      sr_q  <= sr_q << 1;
      idx_q <= idx_q + 1'b1;
      if (idx_q == BW'(DW-1)) full_q <= 1'b0;
    end
  end

  assign ready_o    = en_i && !full_q;
  assign cclk_o     = full_q && ph_q;
  assign din_o      = full_q && sr_q[DW-1];
  assign last_bit_o = full_q && ph_q && last_q && (idx_q == BW'(DW-1));
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import fpga_cfg_pkg::*;
#(
  parameter int DW          = 8,
  parameter int INIT_LO_US  = 100,
  parameter int INIT_HI_US  = 100,
  parameter int DONE_US     = 1000,
  parameter int RST_US      = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_valid_i,
  input  logic          in_last_i,
  output logic          in_ready_o,
  input  logic          init_i,
  input  logic          done_i,
  output logic          prog_n_o,
  output logic          cclk_o,
  output logic          din_o,
  output logic          busy_o,
  output logic          fin_o,
  output logic [1:0]    status_o
);
  localparam int M1   = (INIT_LO_US > INIT_HI_US) ? INIT_LO_US : INIT_HI_US;
  localparam int M2   = (DONE_US > RST_US) ? DONE_US : RST_US;
  localparam int MAXL = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXL + 1);

  cfg_state_e    st_q, st_d;
  logic [1:0]    res_q, res_d;
  logic [CW-1:0] limit;
  logic          expired, init_s, done_s;
  logic          sh_en, sh_cclk, sh_din, sh_last;

  cfg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({done_i, init_i}),
    .q_o   ({done_s, init_s})
  );

  always_comb begin
    unique case (st_q)
      CS_PROG_LO:   limit = CW'(INIT_LO_US);
      CS_WAIT_INIT: limit = CW'(INIT_HI_US);
      CS_WAIT_DONE: limit = CW'(DONE_US);
      default:      limit = CW'(RST_US);
    endcase
  end

  cfg_tick_timer #(.CW(CW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (st_d != st_q),
    .tick_i   (tick_i),
    .limit_i  (limit),
    .expired_o(expired)
  );

  assign sh_en = (st_q == CS_SHIFT);

  cfg_bit_shifter #(.DW(DW)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (sh_en),
    .data_i    (in_data_i),
    .valid_i   (in_valid_i),
    .last_i    (in_last_i),
    .ready_o   (in_ready_o),
    .cclk_o    (sh_cclk),
    .din_o     (sh_din),
    .last_bit_o(sh_last)
  );

  always_comb begin
    st_d  = st_q;
    res_d = res_q;
    unique case (st_q)
      CS_IDLE, CS_END:
        if (start_i) begin
          st_d  = CS_PROG_HI;
          res_d = RES_OK;
        end
      CS_PROG_HI: st_d = CS_PROG_LO;
      CS_PROG_LO:
        if (!init_s) st_d = CS_WAIT_INIT;
        else if (expired) begin
          st_d  = CS_END;
          res_d = RES_INIT_LO;
        end
      CS_WAIT_INIT:
        if (init_s) st_d = CS_SHIFT;
        else if (expired) begin
          st_d  = CS_END;
          res_d = RES_INIT_HI;
        end
      CS_SHIFT:
        if (sh_last) st_d = CS_WAIT_DONE;
      CS_WAIT_DONE:
        if (done_s) st_d = CS_RST_LO;
        else if (expired) begin
          st_d  = CS_END;
          res_d = RES_DONE;
        end
      CS_RST_LO:
        if (expired) st_d = CS_RST_HI;
      CS_RST_HI:
        if (expired) begin
          st_d  = CS_END;
          res_d = RES_OK;
        end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CS_IDLE;
      res_q <= RES_OK;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
    end
  end

  assign prog_n_o = (st_q != CS_PROG_LO);
  assign cclk_o   = sh_en ? sh_cclk : (st_q == CS_RST_LO || st_q == CS_RST_HI);
  assign din_o    = sh_en ? sh_din  : (st_q == CS_RST_HI);
  assign busy_o   = (st_q != CS_IDLE) && (st_q != CS_END);
  assign fin_o    = (st_q == CS_END);
  assign status_o = res_q;
endmodule

// File: rtl/fpga_cfg_seq_chk.sv
module fpga_cfg_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       in_ready_o,
  input logic       prog_n_o,
  input logic       cclk_o,
  input logic       din_o,
  input logic       busy_o,
  input logic       fin_o,
  input logic [1:0] status_o
);
  AST_IDLE_PINS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (prog_n_o && !cclk_o && !din_o && !in_ready_o)); // R1

  AST_PROG_HI_THEN_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> prog_n_o ##1 !prog_n_o); // R2

  AST_DIN_STABLE_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_o) |-> $stable(din_o)); // R5

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_o && !start_i) |=> (fin_o && $stable(status_o))); // R8

  AST_READY_ONLY_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (busy_o && !fin_o)); // R8

  AST_FIN_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> !busy_o); // R9
endmodule

bind fpga_cfg_seq fpga_cfg_seq_chk u_chk (.*);

// File: tb/sim_fpga_cfg_seq.sv
module sim_fpga_cfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TD         = 4;
  localparam int P_INIT_LO  = 6;
  localparam int P_INIT_HI  = 6;
  localparam int P_DONE     = 8;
  localparam int P_RST      = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_valid_i = 1'b0;
  logic       in_last_i = 1'b0;
  logic       init_i = 1'b1;
  logic       done_i = 1'b0;
  logic       in_ready_o, prog_n_o, cclk_o, din_o, busy_o, fin_o;
  logic [1:0] status_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpga_cfg_seq #(
    .DW(8), .INIT_LO_US(P_INIT_LO), .INIT_HI_US(P_INIT_HI),
    .DONE_US(P_DONE), .RST_US(P_RST), .SYNC_STAGES(2)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .init_i(init_i), .done_i(done_i),
    .prog_n_o(prog_n_o), .cclk_o(cclk_o), .din_o(din_o), .busy_o(busy_o),
    .fin_o(fin_o), .status_o(status_o)
  );

  // target model controls
  bit         allow_lo = 1, allow_hi = 1, allow_done = 1;
  int         lo_dly = 2, hi_dly = 2, done_dly = 2;
  int         exp_bits = 0, cap_cnt = 0;
  logic [7:0] cap_q [16];
  logic [7:0] exp_q [16];
  bit         post = 0;
  int         ph_a = 0, ph_b = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_status(input int mode);
    return mode;  // mode 0 ok, 1..3 map onto the three timeout codes
  endfunction

  initial begin : tick_gen
    int tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % TD;
      tick_i = (tc == 0);
    end
  end

  initial begin : target_model
    logic prev_cclk = 1'b0;
    int ic = 0, dc = 0;
    forever begin
      @(negedge clk);
      if (cclk_o && !prev_cclk && cap_cnt < exp_bits) begin
        cap_q[cap_cnt/8] = {cap_q[cap_cnt/8][6:0], din_o};
        cap_cnt++;
      end
      prev_cclk = cclk_o;
      if (exp_bits > 0 && cap_cnt == exp_bits && !cclk_o) post = 1;
      if (post && busy_o && prog_n_o && cclk_o && !din_o) ph_a++;
      if (post && busy_o && prog_n_o && cclk_o && din_o) ph_b++;
      if (!prog_n_o && init_i && allow_lo) begin
        ic++;
        if (ic >= lo_dly) begin init_i = 1'b0; ic = 0; end
      end else if (prog_n_o && !init_i && allow_hi) begin
        ic++;
        if (ic >= hi_dly) begin init_i = 1'b1; ic = 0; end
      end else ic = 0;
      if (!prog_n_o) begin
        done_i = 1'b0; dc = 0;
      end else if (exp_bits > 0 && cap_cnt == exp_bits && !done_i && allow_done) begin
        dc++;
        if (dc >= done_dly) begin done_i = 1'b1; dc = 0; end
      end
    end
  end

  initial begin : watchdog
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(1'b0, "watchdog", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  task automatic send_bytes(input int n, input int gap_max);
    for (int i = 0; i < n; i++) begin
      int g = (gap_max > 0) ? int'($urandom_range(gap_max, 0)) : 0;
      for (int k = 0; k < g; k++) @(negedge clk);
      in_data_i  = 8'($urandom);
      in_last_i  = (i == n - 1);
      in_valid_i = 1'b1;
      exp_q[i]   = in_data_i;
      while (!in_ready_o) @(negedge clk);
      @(negedge clk);
      in_valid_i = 1'b0;
      in_last_i  = 1'b0;
    end
  endtask

  task automatic run_cfg(input int nbytes, input int mode, input int gap_max);
    int w = 0;
    bit ok;
    allow_lo   = (mode != 1);
    allow_hi   = (mode != 2);
    allow_done = (mode != 3);
    lo_dly   = int'($urandom_range(8, 1));
    hi_dly   = int'($urandom_range(8, 1));
    done_dly = int'($urandom_range(10, 1));
    exp_bits = (mode == 0 || mode == 3) ? nbytes * 8 : 0;
    cap_cnt = 0; post = 0; ph_a = 0; ph_b = 0;
    for (int i = 0; i < 16; i++) cap_q[i] = '0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(prog_n_o == 1'b1, "R2 prog high after start", prog_n_o, 1);
    chk(busy_o == 1'b1 && fin_o == 1'b0, "R9 busy after start", busy_o, 1);
    @(negedge clk);
    chk(prog_n_o == 1'b0, "R2 prog low second cycle", prog_n_o, 0);
    if (mode == 0 || mode == 3) send_bytes(nbytes, gap_max);
    while (!fin_o && w < 20000) begin @(negedge clk); w++; end
    chk(fin_o && !busy_o, "R9 run ends not busy", fin_o, 1);
    case (mode)
      1: chk(status_o == 2'(exp_status(mode)), "R3 init-low timeout code", status_o, 1);
      2: chk(status_o == 2'(exp_status(mode)), "R4 init-high timeout code", status_o, 2);
      3: chk(status_o == 2'(exp_status(mode)), "R6 done timeout code", status_o, 3);
      default: chk(status_o == 2'(exp_status(mode)), "R7 ok code", status_o, 0);
    endcase
    if (mode == 0 || mode == 3) begin
      for (int i = 0; i < nbytes; i++)
        chk(cap_q[i] == exp_q[i], "R5 byte msb first", cap_q[i], exp_q[i]);
    end
    if (mode == 0) begin
      chk(ph_a >= (P_RST-1)*TD+2 && ph_a <= P_RST*TD+1, "R7 data-low phase cycles", ph_a, P_RST*TD);
      chk(ph_b >= (P_RST-1)*TD+2 && ph_b <= P_RST*TD+1, "R7 data-high phase cycles", ph_b, P_RST*TD);
    end else begin
      ok = 1;
      in_valid_i = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (in_ready_o || !fin_o || status_o != 2'(mode)) ok = 0;
      end
      in_valid_i = 1'b0;
      chk(ok, "R8 error held, input refused", in_ready_o, 0);
    end
  endtask

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(prog_n_o && !in_ready_o && !busy_o && !cclk_o && !din_o && !fin_o,
        "R1 reset outputs", {prog_n_o, in_ready_o, busy_o, cclk_o}, 8);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(prog_n_o && !in_ready_o && !busy_o, "R1 idle outputs", prog_n_o, 1);

    run_cfg(1, 0, 0);
    run_cfg(3, 0, 4);
    run_cfg(2, 1, 0);
    run_cfg(2, 0, 2);
    run_cfg(2, 2, 0);
    run_cfg(4, 3, 3);
    run_cfg(1, 0, 0);
    for (int r = 0; r < 12; r++) begin
      int m = (($urandom % 4) == 0) ? int'($urandom_range(3, 1)) : 0;
      run_cfg(int'($urandom_range(12, 1)), m, int'($urandom_range(5, 0)));
    end

    // reset during shifting
    allow_lo = 1; allow_hi = 1; exp_bits = 8; cap_cnt = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    begin
      int w = 0;
      while (!in_ready_o && w < 2000) begin @(negedge clk); w++; end
    end
    chk(in_ready_o, "R5 stream opens after handshake", in_ready_o, 1);
    rst_ni = 1'b0;
    #1;
    chk(prog_n_o && !in_ready_o && !busy_o && !cclk_o, "R1 reset mid-run", in_ready_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    run_cfg(2, 0, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule